// File: doc/BRIEF.md
# Free-Running ADC Scan Sequencer

This block runs a single successive-approximation conversion engine over four multiplexed analog inputs. It scans the inputs in a round-robin loop and keeps the newest 10-bit result for each one. The analog side stays outside the block. The block drives a mux select and a 10-bit trial code toward an external DAC and comparator. It reads back one decision bit for each trial.

A programmable divider derives the conversion clock from the system clock. Every step of the engine advances on one pulse of that clock. A control byte sets which inputs take part in the scan, and a run bit lets the engine loop or freezes it so that software can read stable results.

Results leave the block as two bytes per channel, and a strobe marks each freshly stored value.

Top module: `adc_scan_seq`

## Requirements
- R1: After reset the engine is idle (`scanning` low), no strobe is raised, every stored result reads 0, and the divider field is 0.
- R2: A control write latches `ctrl_wdata`. Channel c (0..3) takes part when bit 4-c is 1. Bit 5 is the run bit, and no conversion starts while it is 0.
- R3: While the channel-0 enable (bit 4) is 0, no channel starts a conversion, whatever the other enables hold.
- R4: The divider field is written through `div_we`/`div_field`. The conversion clock pulse `conv_tick` fires once every field+1 system cycles, so a field of 3 gives a divide-by-4.
- R5: Each conversion spends exactly 12 conversion ticks: one settle tick, then ten bit trials from MSB to LSB, then one store tick. While N channels are active, the same channel is stored every 12·N·(field+1) cycles.
- R6: `cmp_bit`=1 means the input is at or above `trial_code`, and the bit on trial is then kept. The stored result equals the 10-bit input code.
- R7: Active channels are served in ascending index order, wrapping from 3 back to 0. Each new conversion takes the next active channel after the last one stored.
- R8: Clearing the run bit lets the conversion in progress run to its store. After that store the engine goes idle and every stored result holds until the engine runs again.
- R9: A control write takes effect from the following edge. A run-bit clear that lands on the same edge as a store still lets the next channel start, but a clear one edge earlier does not.
- R10: Readout of channel `rd_chan` is combinational. `rd_byte_lo` holds result bits 7..0. `rd_byte_hi` holds bits 9..8 in its bits 1..0, and its bits 7..2 are zero.
- R11: `res_valid` is high for exactly one cycle, in the cycle right after the store edge, and `res_chan` gives the channel index. The new value can be read in that same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ctrl_we | input | 1 | Control byte write strobe |
| ctrl_wdata | input | 8 | Control byte: run in bit 5, enables in bits 4..1 |
| div_we | input | 1 | Divider field write strobe |
| div_field | input | 3 | Conversion clock divide ratio minus one |
| cmp_bit | input | 1 | Comparator decision: input at or above trial code |
| trial_code | output | 10 | Code applied to the external DAC |
| mux_sel | output | 2 | Input multiplexer select |
| conv_tick | output | 1 | One-cycle conversion clock pulse |
| scanning | output | 1 | Engine busy with a conversion |
| rd_chan | input | 2 | Channel selected for readout |
| rd_byte_lo | output | 8 | Result bits 7..0 of the selected channel |
| rd_byte_hi | output | 8 | Result bits 9..8, zero-extended |
| res_valid | output | 1 | One-cycle store strobe |
| res_chan | output | 2 | Channel index of the strobe |

## Verification
Two of the block's functions can fall on the same clock edge. One is a control write that clears the run bit. The other is the engine's store-and-choose-next decision. The bench waits for one store strobe, counts twelve divided conversion periods from it, and places the run-bit clear either exactly on the next store edge or one system cycle before it. It then counts the strobes that follow and expects two in the first case and one in the second. The scans with different masks also test the channel ordering and the period between stores of the same channel.

// File: rtl/adc_scan_pkg.sv
package adc_scan_pkg;

  localparam int unsigned SCAN_CH      = 4;
  localparam int unsigned CTRL_RUN_POS = 5;
  localparam int unsigned CTRL_ACT_TOP = 4;
  localparam int unsigned TICKS_PER_CH = 12;

  typedef enum logic [1:0] {
    PH_IDLE   = 2'd0,
    PH_SETTLE = 2'd1,
    PH_BIT    = 2'd2,
    PH_STORE  = 2'd3
  } phase_t;

  // control-byte bit that enables channel ch
  function automatic int unsigned act_pos(input int unsigned ch);
    return CTRL_ACT_TOP - ch;
  endfunction

endpackage

// File: rtl/conv_clk_div.sv
module conv_clk_div #(
  parameter int unsigned DIV_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             div_we,
  input  logic [DIV_W-1:0] div_field,
  output logic             tick,
  output logic [DIV_W:0]   ratio
);

  logic [DIV_W-1:0] field_q;
  logic [DIV_W:0]   cnt_q;

  function automatic logic [DIV_W:0] ratio_of(input logic [DIV_W-1:0] f);
    return {1'b0, f} + 1'b1;
  endfunction

  assign ratio = ratio_of(field_q);
  assign tick  = (cnt_q == ratio - 1'b1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      field_q <= '0;
      cnt_q   <= '0;
    end else if (div_we) begin
      field_q <= div_field;
      cnt_q   <= '0;
    end else if (tick) begin
      cnt_q   <= '0;
    end else begin
      cnt_q   <= cnt_q + 1'b1;
    end
  end

endmodule

// File: rtl/scan_pick.sv
module scan_pick #(
  parameter int unsigned CH_N = 4,
  localparam int unsigned CH_W = $clog2(CH_N)
) (
  input  logic [CH_W-1:0] last_ch,
  input  logic [CH_N-1:0] mask,
  output logic [CH_W-1:0] next_ch,
  output logic            found
);

  always_comb begin
    next_ch = last_ch;
    found   = 1'b0;
    for (int off = 1; off <= int'(CH_N); off++) begin
      automatic int unsigned idx = (int'(last_ch) + off) % CH_N;
      if (!found && mask[idx]) begin
        next_ch = CH_W'(idx);
        found   = 1'b1;
      end
    end
  end

endmodule

// File: rtl/sar_engine.sv
module sar_engine
  import adc_scan_pkg::*;
#(
  parameter int unsigned RES_W = 10,
  parameter int unsigned CH_N  = 4,
  localparam int unsigned CH_W = $clog2(CH_N),
  localparam int unsigned BW   = $clog2(RES_W)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             go,
  input  logic [CH_W-1:0]  next_ch,
  input  logic             cmp_bit,
  output logic [RES_W-1:0] trial,
  output logic [CH_W-1:0]  cur_ch,
  output phase_t           phase,
  output logic             store_en,
  output logic [RES_W-1:0] store_data
);

  phase_t           phase_q;
  logic [BW-1:0]    bit_q;
  logic [RES_W-1:0] acc_q;
  logic [CH_W-1:0]  ch_q;

  function automatic logic [RES_W-1:0] trial_of(input logic [RES_W-1:0] acc,
                                                input logic [BW-1:0]    b);
    return acc | (RES_W'(1) << b);
  endfunction

  assign phase      = phase_q;
  assign cur_ch     = ch_q;
  assign trial      = (phase_q == PH_BIT) ? trial_of(acc_q, bit_q) : acc_q;
  assign store_en   = tick && (phase_q == PH_STORE);
  assign store_data = acc_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      bit_q   <= '0;
      acc_q   <= '0;
      ch_q    <= CH_W'(CH_N - 1);
    end else if (tick) begin
      unique case (phase_q)
        PH_IDLE, PH_STORE: begin
          if (go) begin
            phase_q <= PH_SETTLE;
            ch_q    <= next_ch;
            acc_q   <= '0;
          end else begin
            phase_q <= PH_IDLE;
          end
        end
        PH_SETTLE: begin
          phase_q <= PH_BIT;
          bit_q   <= BW'(RES_W - 1);
        end
        PH_BIT: begin
          if (cmp_bit) acc_q[bit_q] <= 1'b1;
          if (bit_q == '0) phase_q <= PH_STORE;
          else             bit_q   <= bit_q - 1'b1;
        end
        default: phase_q <= PH_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/result_bank.sv
module result_bank #(
  parameter int unsigned RES_W = 10,
  parameter int unsigned CH_N  = 4,
  localparam int unsigned CH_W = $clog2(CH_N)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             store_en,
  input  logic [CH_W-1:0]  store_ch,
  input  logic [RES_W-1:0] store_data,
  input  logic [CH_W-1:0]  rd_chan,
  output logic [7:0]       rd_byte_lo,
  output logic [7:0]       rd_byte_hi,
  output logic             res_valid,
  output logic [CH_W-1:0]  res_chan
);

  logic [RES_W-1:0] res_q [CH_N];
  logic             valid_q;
  logic [CH_W-1:0]  vch_q;

  function automatic logic [7:0] low_part(input logic [RES_W-1:0] v);
    return v[7:0];
  endfunction

  function automatic logic [7:0] high_part(input logic [RES_W-1:0] v);
    return 8'(v >> 8);
  endfunction

  for (genvar g = 0; g < CH_N; g++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                   res_q[g] <= '0;
      else if (store_en && store_ch == CH_W'(g))    res_q[g] <= store_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      vch_q   <= '0;
    end else begin
      valid_q <= store_en;
      if (store_en) vch_q <= store_ch;
    end
  end

  assign rd_byte_lo = low_part(res_q[rd_chan]);
  assign rd_byte_hi = high_part(res_q[rd_chan]);
  assign res_valid  = valid_q;
  assign res_chan   = vch_q;

endmodule

// File: rtl/adc_scan_seq.sv
module adc_scan_seq
  import adc_scan_pkg::*;
#(
  parameter int unsigned RES_W = 10,
  parameter int unsigned DIV_W = 3,
  localparam int unsigned CH_N = SCAN_CH,
  localparam int unsigned CH_W = $clog2(CH_N)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ctrl_we,
  input  logic [7:0]       ctrl_wdata,
  input  logic             div_we,
  input  logic [DIV_W-1:0] div_field,
  input  logic             cmp_bit,
  output logic [RES_W-1:0] trial_code,
  output logic [CH_W-1:0]  mux_sel,
  output logic             conv_tick,
  output logic             scanning,
  input  logic [CH_W-1:0]  rd_chan,
  output logic [7:0]       rd_byte_lo,
  output logic [7:0]       rd_byte_hi,
  output logic             res_valid,
  output logic [CH_W-1:0]  res_chan
);

  logic             run_q;
  logic [CH_N-1:0]  act_q;
  logic [CH_N-1:0]  act_in;
  logic             ctrl_unused;
  logic             tick_w;
  logic [DIV_W:0]   ratio_w;
  logic [CH_N-1:0]  pick_mask;
  logic [CH_W-1:0]  next_ch_w;
  logic             found_w;
  logic             go_w;
  phase_t           phase_w;
  logic             store_en_w;
  logic [RES_W-1:0] store_data_w;
  logic [CH_W-1:0]  cur_ch_w;

  for (genvar g = 0; g < CH_N; g++) begin : g_act
    assign act_in[g] = ctrl_wdata[act_pos(g)];
  end
  assign ctrl_unused = ^{ctrl_wdata[7:6], ctrl_wdata[0]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= 1'b0;
      act_q <= '0;
    end else if (ctrl_we) begin
      run_q <= ctrl_wdata[CTRL_RUN_POS];
      act_q <= act_in;
    end
  end

  // channel 0 gates every other channel
  assign pick_mask = act_q & {CH_N{act_q[0]}};
  assign go_w      = run_q && found_w;

  conv_clk_div #(.DIV_W(DIV_W)) u_div (
    .clk       (clk),
    .rst_n     (rst_n),
    .div_we    (div_we),
    .div_field (div_field),
    .tick      (tick_w),
    .ratio     (ratio_w)
  );

  scan_pick #(.CH_N(CH_N)) u_pick (
    .last_ch (cur_ch_w),
    .mask    (pick_mask),
    .next_ch (next_ch_w),
    .found   (found_w)
  );

  sar_engine #(.RES_W(RES_W), .CH_N(CH_N)) u_eng (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick       (tick_w),
    .go         (go_w),
    .next_ch    (next_ch_w),
    .cmp_bit    (cmp_bit),
    .trial      (trial_code),
    .cur_ch     (cur_ch_w),
    .phase      (phase_w),
    .store_en   (store_en_w),
    .store_data (store_data_w)
  );

  result_bank #(.RES_W(RES_W), .CH_N(CH_N)) u_bank (
    .clk        (clk),
    .rst_n      (rst_n),
    .store_en   (store_en_w),
    .store_ch   (cur_ch_w),
    .store_data (store_data_w),
    .rd_chan    (rd_chan),
    .rd_byte_lo (rd_byte_lo),
    .rd_byte_hi (rd_byte_hi),
    .res_valid  (res_valid),
    .res_chan   (res_chan)
  );

  assign mux_sel   = cur_ch_w;
  assign conv_tick = tick_w;
  assign scanning  = (phase_w != PH_IDLE);

endmodule

// File: rtl/adc_scan_seq_chk.sv
module adc_scan_seq_chk
  import adc_scan_pkg::*;
#(
  parameter int unsigned DIV_W = 3,
  parameter int unsigned CH_N  = 4,
  localparam int unsigned CH_W = $clog2(CH_N)
) (
  input logic            clk,
  input logic            rst_n,
  input phase_t          phase,
  input logic            tick,
  input logic [DIV_W:0]  ratio,
  input logic            div_we,
  input logic            store_en,
  input logic            res_valid,
  input logic            scanning,
  input logic            run,
  input logic [CH_N-1:0] act,
  input logic [CH_W-1:0] mux_sel,
  input logic [CH_W-1:0] rd_chan,
  input logic [7:0]      rd_byte_lo
);

  logic in_settle;
  assign in_settle = (phase == PH_SETTLE);

  AST_START_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(in_settle) |-> ($past(run) && $past(act[0]) &&
                          ((($past(act) >> mux_sel) & 1) != 0))); // R3

  AST_GATED_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!scanning && !act[0]) |=> !scanning); // R3

  AST_TICK_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && ratio > 1 && !div_we) |=> !tick); // R4

  AST_STORE_FROM_BITS: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(phase == PH_STORE) |-> $past(phase) == PH_BIT); // R5

  AST_VALID_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |=> !res_valid); // R11

  AST_IDLE_NO_STORE: assert property (@(posedge clk) disable iff (!rst_n)
    !scanning |=> !res_valid); // R8

  AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !store_en |=> (rd_chan != $past(rd_chan)) || $stable(rd_byte_lo)); // R8

endmodule

bind adc_scan_seq adc_scan_seq_chk #(.DIV_W(DIV_W), .CH_N(CH_N)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .phase      (phase_w),
  .tick       (tick_w),
  .ratio      (ratio_w),
  .div_we     (div_we),
  .store_en   (store_en_w),
  .res_valid  (res_valid),
  .scanning   (scanning),
  .run        (run_q),
  .act        (act_q),
  .mux_sel    (mux_sel),
  .rd_chan    (rd_chan),
  .rd_byte_lo (rd_byte_lo)
);

// File: tb/adc_scan_seq_tb.sv
module adc_scan_seq_tb;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ctrl_we = 1'b0;
  logic [7:0] ctrl_wdata = '0;
  logic       div_we = 1'b0;
  logic [2:0] div_field = '0;
  logic       cmp_bit;
  logic [9:0] trial_code;
  logic [1:0] mux_sel;
  logic       conv_tick;
  logic       scanning;
  logic [1:0] rd_chan = '0;
  logic [7:0] rd_byte_lo;
  logic [7:0] rd_byte_hi;
  logic       res_valid;
  logic [1:0] res_chan;

  always #10 clk = ~clk;

  adc_scan_seq u_dut (
    .clk(clk), .rst_n(rst_n), .ctrl_we(ctrl_we), .ctrl_wdata(ctrl_wdata),
    .div_we(div_we), .div_field(div_field), .cmp_bit(cmp_bit),
    .trial_code(trial_code), .mux_sel(mux_sel), .conv_tick(conv_tick),
    .scanning(scanning), .rd_chan(rd_chan), .rd_byte_lo(rd_byte_lo),
    .rd_byte_hi(rd_byte_hi), .res_valid(res_valid), .res_chan(res_chan)
  );

  // analog side: input codes per channel and an ideal comparator
  logic [9:0] vin [4];
  assign cmp_bit = (vin[mux_sel] >= trial_code);

  int total = 0;
  int bad = 0;

  task automatic chk(input string req, input int act, input int exp, input string what);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // strobe monitor
  int unsigned cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  logic [3:0]  mon_mask = '0;
  int          exp_period = 0;
  int          strobe_cnt = 0;
  int          order_bad = 0;
  int          period_bad = 0;
  int          last_ch = 3;
  int unsigned prev0 = 0;
  bit          have0 = 0;

  function automatic int next_active(input int last, input logic [3:0] m);
    int c = last;
    for (int k = 0; k < 4; k++) begin
      c = (c == 3) ? 0 : c + 1;
      if (m[c]) return c;
    end
    return last;
  endfunction

  always @(negedge clk) begin
    if (rst_n && res_valid) begin
      strobe_cnt++;
      if (int'(res_chan) != next_active(last_ch, mon_mask)) order_bad++;
      last_ch = int'(res_chan);
      if (res_chan == 2'd0) begin
        if (have0 && exp_period != 0 && int'(cyc - prev0) != exp_period) period_bad++;
        prev0 = cyc;
        have0 = 1;
      end
    end
  end

  function automatic logic [3:0] mask_of(input logic [7:0] c);
    logic [3:0] m;
    for (int i = 0; i < 4; i++) m[i] = c[4 - i];
    return m;
  endfunction

  task automatic wr_ctrl(input logic [7:0] v);
    @(negedge clk);
    ctrl_wdata = v;
    ctrl_we = 1'b1;
    @(negedge clk);
    ctrl_we = 1'b0;
  endtask

  task automatic wr_div(input logic [2:0] v);
    @(negedge clk);
    div_field = v;
    div_we = 1'b1;
    @(negedge clk);
    div_we = 1'b0;
  endtask

  task automatic clear_mon();
    strobe_cnt = 0; order_bad = 0; period_bad = 0; have0 = 0;
  endtask

  task automatic wait_strobe();
    for (int i = 0; i < 2000; i++) begin
      @(negedge clk);
      if (res_valid) return;
    end
    chk("R5", 0, 1, "strobe timeout");
  endtask

  task automatic wait_idle(input string req);
    for (int i = 0; i < 200; i++) begin
      @(negedge clk);
      if (!scanning) return;
    end
    chk(req, 1, 0, "engine never went idle");
  endtask

  // stimulus / expectation vectors
  localparam int NV = 6;
  localparam logic [2:0]  V_DIV  [NV] = '{3'd0, 3'd3, 3'd1, 3'd2, 3'd0, 3'd7};
  localparam logic [7:0]  V_CTRL [NV] = '{8'h3E, 8'h34, 8'h32, 8'h2C, 8'h10, 8'h38};
  localparam logic [39:0] V_IN   [NV] = '{
    {10'h2AA, 10'h155, 10'h3FF, 10'h000},
    {10'h200, 10'h0FF, 10'h111, 10'h3A5},
    {10'h3FE, 10'h080, 10'h07F, 10'h001},
    {10'h123, 10'h321, 10'h0AA, 10'h055},
    {10'h3C3, 10'h2D2, 10'h1E1, 10'h0F0},
    {10'h10F, 10'h2F0, 10'h1FF, 10'h200}
  };

  logic [9:0] exp_res [4];

  initial begin
    for (int i = 0; i < 4; i++) begin vin[i] = '0; exp_res[i] = '0; end
    repeat (200000) @(posedge clk);
    chk("R5", 0, 1, "watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: reset state
    @(negedge clk);
    chk("R1", scanning, 0, "scanning after reset");
    chk("R1", res_valid, 0, "strobe after reset");
    for (int c = 0; c < 4; c++) begin
      rd_chan = 2'(c);
      #1;
      chk("R1", {rd_byte_hi, rd_byte_lo}, 0, "result after reset");
    end
    // R4: reset field 0 gives a pulse on every cycle
    chk("R4", conv_tick, 1, "tick at ratio 1 (a)");
    @(negedge clk);
    chk("R4", conv_tick, 1, "tick at ratio 1 (b)");

    // R4: divide-by-4 for a field of 3
    wr_div(3'd3);
    begin
      int n = 0;
      for (int i = 0; i < 40; i++) begin
        @(negedge clk);
        if (conv_tick) n++;
      end
      chk("R4", n, 10, "ticks in 40 cycles at field 3");
    end

    // vector loop: R2 R3 R5 R6 R7 R10
    for (int v = 0; v < NV; v++) begin
      logic [3:0] m;
      bit gate;
      int n_act;
      m = mask_of(V_CTRL[v]);
      gate = V_CTRL[v][5] && m[0];
      n_act = $countones(m);
      for (int c = 0; c < 4; c++) vin[c] = V_IN[v][c*10 +: 10];
      wr_div(V_DIV[v]);
      mon_mask = m;
      exp_period = 12 * n_act * (int'(V_DIV[v]) + 1);
      clear_mon();
      wr_ctrl(V_CTRL[v]);
      repeat (gate ? 3 * exp_period + 40 : 400) @(negedge clk);
      if (gate) begin
        chk("R2", int'(strobe_cnt >= 2 * n_act), 1, $sformatf("strobes seen v%0d", v));
        chk("R7", order_bad, 0, $sformatf("channel order v%0d", v));
        chk("R5", period_bad, 0, $sformatf("same-channel period v%0d", v));
        for (int c = 0; c < 4; c++) if (m[c]) exp_res[c] = vin[c];
      end else begin
        chk(V_CTRL[v][5] ? "R3" : "R2", strobe_cnt, 0, $sformatf("no conversions v%0d", v));
        chk(V_CTRL[v][5] ? "R3" : "R2", scanning, 0, $sformatf("stays idle v%0d", v));
      end
      wr_ctrl(V_CTRL[v] & 8'hDF);
      wait_idle("R8");
      for (int c = 0; c < 4; c++) begin
        rd_chan = 2'(c);
        #1;
        chk("R6", {rd_byte_hi[1:0], rd_byte_lo}, exp_res[c], $sformatf("value v%0d ch%0d", v, c));
        chk("R10", rd_byte_hi[7:2], 0, $sformatf("upper zero v%0d ch%0d", v, c));
      end
    end

    // R10: explicit byte split of 0x3A5 stored on channel 0 by vector 1
    rd_chan = 2'd0;
    exp_res[0] = 10'h3A5;
    vin[0] = 10'h3A5;
    wr_div(3'd0);
    mon_mask = 4'b0001;
    exp_period = 12;
    wr_ctrl(8'h30);
    wait_strobe();
    // R11: strobe names the channel and the value is readable in that cycle
    chk("R11", res_chan, 0, "strobe channel");
    chk("R10", rd_byte_lo, 8'hA5, "low byte of 3A5");
    chk("R10", rd_byte_hi, 8'h03, "high byte of 3A5");
    @(negedge clk);
    chk("R11", res_valid, 0, "strobe lasts one cycle");

    // R8: clearing run mid-conversion lets it finish, then results hold
    wr_div(3'd1);
    vin[0] = 10'h0C3;
    wait_strobe();
    repeat (5) @(negedge clk);
    clear_mon();
    wr_ctrl(8'h10);
    repeat (100) @(negedge clk);
    chk("R8", strobe_cnt, 1, "strobes after mid-conversion stop");
    chk("R8", scanning, 0, "idle after stop");
    #1;
    chk("R8", {rd_byte_hi[1:0], rd_byte_lo}, 10'h0C3, "finished conversion stored");
    vin[0] = 10'h001;
    repeat (100) @(negedge clk);
    chk("R8", {rd_byte_hi[1:0], rd_byte_lo}, 10'h0C3, "result held while frozen");

    // R9: run clear on the store edge versus one edge earlier (ratio 2)
    vin[0] = 10'h2F0;
    vin[1] = 10'h05A;
    mon_mask = 4'b0011;
    exp_period = 48;
    wr_ctrl(8'h38);
    wait_strobe();
    repeat (23) @(posedge clk);
    clear_mon();
    wr_ctrl(8'h18);
    repeat (120) @(negedge clk);
    chk("R9", strobe_cnt, 2, "clear on the store edge");
    wait_idle("R9");

    wr_ctrl(8'h38);
    wait_strobe();
    repeat (22) @(posedge clk);
    clear_mon();
    wr_ctrl(8'h18);
    repeat (120) @(negedge clk);
    chk("R9", strobe_cnt, 1, "clear one edge before the store");
    chk("R7", order_bad, 0, "order across stop/start");

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule